// File: doc/BRIEF.md
# Serial Port Request Arbiter

This block sits beside a serial port and turns its receive and transmit events into exactly one request toward the rest of the chip. Each direction has a routing bit. When the bit is set, that direction's event becomes a DMA request. When it is clear, the event becomes an interrupt request. At most one request is presented at a time. The choice follows a fixed internal order: both DMA requests rank above both interrupt requests, and within each pair receive ranks above transmit. A 3-bit system level goes out with the granted request. The all-ones value of that level means the port has no priority, and then nothing is presented.

Each direction also has a transaction counter. Software loads it, and every acknowledged DMA transfer in that direction decrements it. When the decrement reaches zero, hardware clears that direction's routing bit, so later events fall back to interrupts. At the same moment it raises a sticky end-of-block flag, which software clears by writing a one. The DMA engine and the interrupt controller that consume these outputs are outside this block.

Top module: `spa_arbiter`

## Requirements
- R1: A pulse on `rx_evt_i` makes receive pending. A pulse on either `txb_evt_i` or `txs_evt_i` makes transmit pending. A pending direction stays pending until its request is acknowledged, and an event in the same cycle as its acknowledge leaves it pending.
- R2: `mask_wr_i` loads the routing bits from `mask_wdata_i` (bit 0 receive, bit 1 transmit), visible on `dma_mask_o` in the same bit order. A pending direction with routing bit 1 is requested as DMA, and with routing bit 0 as interrupt. `req_kind_o` encodes 0 = receive DMA, 1 = transmit DMA, 2 = receive interrupt, 3 = transmit interrupt.
- R3: When several candidates exist, the grant goes to receive DMA first, then transmit DMA, then receive interrupt, then transmit interrupt.
- R4: If `prio_i` is 7, or nothing is pending, `req_valid_o` is 0, `req_kind_o` is 0 and `req_level_o` is 7. In that state an `ack_i` is ignored. Otherwise `req_level_o` equals `prio_i`.
- R5: `ack_i` while `req_valid_o` is 1 clears the pending state of the granted direction only, from the next cycle on.
- R6: `cnt_wr_i` loads `cnt_wdata_i` into the counter chosen by `cnt_sel_i` (0 receive, 1 transmit). An acknowledged DMA grant decrements that direction's nonzero counter. When the counter reaches zero, that direction's routing bit clears and its end-of-block bit on `eob_o` (bit 0 receive, bit 1 transmit) sets, both in the same cycle.
- R7: An acknowledged DMA grant in a direction whose counter is already zero changes neither its routing bit nor its end-of-block bit.
- R8: An end-of-block bit stays set until a one is written to the same bit of `eob_clr_i`. Writing a one to the other bit leaves it set.
- R9: After reset nothing is pending, both routing bits are 0, both end-of-block bits are 0 and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_evt_i | input | 1 | Receive data ready event pulse |
| txb_evt_i | input | 1 | Transmit buffer empty event pulse |
| txs_evt_i | input | 1 | Transmit shifter empty event pulse |
| mask_wr_i | input | 1 | Write strobe for the routing bits |
| mask_wdata_i | input | 2 | Routing bits: bit 0 receive, bit 1 transmit |
| cnt_wr_i | input | 1 | Counter load strobe |
| cnt_sel_i | input | 1 | Counter select: 0 receive, 1 transmit |
| cnt_wdata_i | input | CNT_W | Counter load value |
| prio_i | input | PRIO_W | System level; all ones means no priority |
| ack_i | input | 1 | Single-cycle acknowledge of the granted request |
| eob_clr_i | input | 2 | Write-one-to-clear for the end-of-block bits |
| req_valid_o | output | 1 | A request is presented |
| req_kind_o | output | 2 | Granted request type |
| req_level_o | output | PRIO_W | Level presented with the request |
| dma_mask_o | output | 2 | Current routing bits |
| eob_o | output | 2 | End-of-block flags |

## Verification
The bench builds the block with its default parameters: 8-bit counters and a 3-bit level. With these, the all-ones "no priority" value 7 is one of the stimulus values and not an untested extreme. Loading counts of 0, 1 and 2 brings the zero-crossing and the already-zero cases within a few cycles. A counter of 200 keeps end-of-block out of the way while the grant ordering is walked through every mix of pending directions and routing bits.

// File: rtl/spa_pkg.sv
package spa_pkg;
    localparam int unsigned NUM_DIRS = 2;
    localparam int unsigned DIR_RX   = 0;
    localparam int unsigned DIR_TX   = 1;

    typedef enum logic [1:0] {
        KIND_RX_DMA = 2'd0,
        KIND_TX_DMA = 2'd1,
        KIND_RX_IRQ = 2'd2,
        KIND_TX_IRQ = 2'd3
    } req_kind_e;
endpackage

// File: rtl/spa_chan.sv
module spa_chan #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic             mask_wr_i,
    input  logic             mask_val_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] cnt_val_i,
    input  logic             ack_i,
    input  logic             ack_dma_i,
    input  logic             eob_clr_i,
    output logic             pend_o,
    output logic             mask_o,
    output logic             eob_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic             pend;
        logic             mask;
        logic             eob;
        logic [CNT_W-1:0] cnt;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mask_wr_i) st_d.mask = mask_val_i;
        if (ack_i)     st_d.pend = 1'b0;
        if (evt_i)     st_d.pend = 1'b1;
        if (eob_clr_i) st_d.eob  = 1'b0;
        if (ack_i && ack_dma_i && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - CNT_ONE;
            if (st_q.cnt == CNT_ONE) begin
                st_d.mask = 1'b0;
                st_d.eob  = 1'b1;
            end
        end
        if (cnt_wr_i) st_d.cnt = cnt_val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign mask_o = st_q.mask;
    assign eob_o  = st_q.eob;
endmodule

// File: rtl/spa_pick.sv
module spa_pick
    import spa_pkg::*;
#(
    parameter int unsigned PRIO_W = 3
) (
    input  logic [NUM_DIRS-1:0] pend_i,
    input  logic [NUM_DIRS-1:0] mask_i,
    input  logic [PRIO_W-1:0]   prio_i,
    output logic                valid_o,
    output req_kind_e           kind_o,
    output logic [PRIO_W-1:0]   level_o,
    output logic                dir_o,
    output logic                dma_o
);
    localparam logic [PRIO_W-1:0] LVL_NONE = '1;

    always_comb begin
        valid_o = 1'b0;
        kind_o  = KIND_RX_DMA;
        level_o = LVL_NONE;
        dir_o   = 1'b0;
        dma_o   = 1'b0;
        if (prio_i != LVL_NONE) begin
            if (pend_i[DIR_RX] && mask_i[DIR_RX]) begin
                valid_o = 1'b1; kind_o = KIND_RX_DMA; dir_o = 1'b0; dma_o = 1'b1;
            end else if (pend_i[DIR_TX] && mask_i[DIR_TX]) begin
                valid_o = 1'b1; kind_o = KIND_TX_DMA; dir_o = 1'b1; dma_o = 1'b1;
            end else if (pend_i[DIR_RX]) begin
                valid_o = 1'b1; kind_o = KIND_RX_IRQ; dir_o = 1'b0;
            end else if (pend_i[DIR_TX]) begin
                valid_o = 1'b1; kind_o = KIND_TX_IRQ; dir_o = 1'b1;
            end
            if (valid_o) level_o = prio_i;
        end
    end
endmodule

// File: rtl/spa_arbiter.sv
module spa_arbiter
    import spa_pkg::*;
#(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned PRIO_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_evt_i,
    input  logic              txb_evt_i,
    input  logic              txs_evt_i,
    input  logic              mask_wr_i,
    input  logic [1:0]        mask_wdata_i,
    input  logic              cnt_wr_i,
    input  logic              cnt_sel_i,
    input  logic [CNT_W-1:0]  cnt_wdata_i,
    input  logic [PRIO_W-1:0] prio_i,
    input  logic              ack_i,
    input  logic [1:0]        eob_clr_i,
    output logic              req_valid_o,
    output logic [1:0]        req_kind_o,
    output logic [PRIO_W-1:0] req_level_o,
    output logic [1:0]        dma_mask_o,
    output logic [1:0]        eob_o
);
    logic [NUM_DIRS-1:0] evt;
    logic [NUM_DIRS-1:0] pend;
    logic [NUM_DIRS-1:0] mask;
    logic [NUM_DIRS-1:0] eob;
    logic                grant_valid;
    req_kind_e           grant_kind;
    logic                grant_dir;
    logic                grant_dma;
    logic                ack_ok;

    assign evt[DIR_RX] = rx_evt_i;
    assign evt[DIR_TX] = txb_evt_i | txs_evt_i;
    assign ack_ok      = ack_i & grant_valid;

    for (genvar g = 0; g < NUM_DIRS; g++) begin : g_dir
        spa_chan #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_i     (evt[g]),
            .mask_wr_i (mask_wr_i),
            .mask_val_i(mask_wdata_i[g]),
            .cnt_wr_i  (cnt_wr_i && (cnt_sel_i == 1'(g))),
            .cnt_val_i (cnt_wdata_i),
            .ack_i     (ack_ok && (grant_dir == 1'(g))),
            .ack_dma_i (grant_dma),
            .eob_clr_i (eob_clr_i[g]),
            .pend_o    (pend[g]),
            .mask_o    (mask[g]),
            .eob_o     (eob[g])
        );
    end

    spa_pick #(.PRIO_W(PRIO_W)) u_pick (
        .pend_i (pend),
        .mask_i (mask),
        .prio_i (prio_i),
        .valid_o(grant_valid),
        .kind_o (grant_kind),
        .level_o(req_level_o),
        .dir_o  (grant_dir),
        .dma_o  (grant_dma)
    );

    assign req_valid_o = grant_valid;
    assign req_kind_o  = grant_kind;
    assign dma_mask_o  = mask;
    assign eob_o       = eob;
endmodule

// File: rtl/spa_arbiter_chk.sv
module spa_arbiter_chk #(
    parameter int unsigned PRIO_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_evt_i,
    input logic              ack_i,
    input logic [PRIO_W-1:0] prio_i,
    input logic [1:0]        eob_clr_i,
    input logic              req_valid_o,
    input logic [1:0]        req_kind_o,
    input logic [1:0]        dma_mask_o,
    input logic [1:0]        eob_o
);
    assert_no_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_i == '1) |-> !req_valid_o);

    assert_rx_irq_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_kind_o == 2'd2) |-> !dma_mask_o[0]);

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && ack_i && req_kind_o == 2'd0 && !rx_evt_i)
        |=> !(req_valid_o && req_kind_o == 2'd0));

    assert_eob_mask_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eob_o[0]) |-> !dma_mask_o[0]);

    assert_eob_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eob_o[1] && !eob_clr_i[1]) |=> eob_o[1]);
endmodule

bind spa_arbiter spa_arbiter_chk #(.PRIO_W(PRIO_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_evt_i   (rx_evt_i),
    .ack_i      (ack_i),
    .prio_i     (prio_i),
    .eob_clr_i  (eob_clr_i),
    .req_valid_o(req_valid_o),
    .req_kind_o (req_kind_o),
    .dma_mask_o (dma_mask_o),
    .eob_o      (eob_o)
);

// File: tb/spa_arbiter_test.sv
`timescale 1ns/1ps
module spa_arbiter_test;
    localparam int CNT_W  = 8;
    localparam int PRIO_W = 3;
    localparam int NVEC   = 16;

    // {rx, txb, txs, mwr, mval[1:0], prio[2:0], ack | valid, kind[1:0], level[2:0]}
    localparam logic [15:0] VEC [NVEC] = '{
        16'b1_0_0_0_00_011_0_1_10_011, // R1 rx event -> rx irq
        16'b0_0_1_0_00_011_0_1_10_011, // R3 rx irq above tx irq
        16'b0_0_0_0_00_011_1_1_11_011, // R5 ack clears rx only
        16'b0_0_0_1_10_011_0_1_01_011, // R2 tx routed to dma
        16'b1_0_0_0_00_011_0_1_01_011, // R3 tx dma above rx irq
        16'b0_0_0_1_11_011_0_1_00_011, // R3 rx dma highest
        16'b0_0_0_0_00_111_0_0_00_111, // R4 level 7 suppresses
        16'b0_0_0_0_00_000_1_1_01_000, // R5 ack rx dma
        16'b0_0_0_0_00_000_1_0_00_111, // R5 ack tx dma, idle
        16'b0_1_0_0_00_101_0_1_01_101, // R1 buffer-empty event
        16'b0_0_0_1_00_101_0_1_11_101, // R2 back to interrupt
        16'b0_0_0_0_00_101_1_0_00_111, // R5 ack tx irq
        16'b1_0_0_0_00_111_0_0_00_111, // R4 pending but level 7
        16'b0_0_0_0_00_111_1_0_00_111, // R4 ack ignored
        16'b0_0_0_0_00_010_0_1_10_010, // R4 still pending
        16'b0_0_0_0_00_010_1_0_00_111  // R5 ack
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx_evt_i = 1'b0, txb_evt_i = 1'b0, txs_evt_i = 1'b0;
    logic              mask_wr_i = 1'b0;
    logic [1:0]        mask_wdata_i = '0;
    logic              cnt_wr_i = 1'b0, cnt_sel_i = 1'b0;
    logic [CNT_W-1:0]  cnt_wdata_i = '0;
    logic [PRIO_W-1:0] prio_i = 3'd3;
    logic              ack_i = 1'b0;
    logic [1:0]        eob_clr_i = '0;
    logic              req_valid_o;
    logic [1:0]        req_kind_o;
    logic [PRIO_W-1:0] req_level_o;
    logic [1:0]        dma_mask_o;
    logic [1:0]        eob_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    spa_arbiter #(.CNT_W(CNT_W), .PRIO_W(PRIO_W)) uut (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_strobes();
        rx_evt_i = 0; txb_evt_i = 0; txs_evt_i = 0; mask_wr_i = 0;
        cnt_wr_i = 0; ack_i = 0; eob_clr_i = '0;
    endtask

    task automatic finish_cycle();
        @(posedge clk); #1; clear_strobes(); #1;
    endtask

    task automatic load_cnt(input logic sel, input int val);
        @(negedge clk); cnt_wr_i = 1; cnt_sel_i = sel; cnt_wdata_i = CNT_W'(val);
        finish_cycle();
    endtask

    task automatic set_mask(input logic [1:0] m);
        @(negedge clk); mask_wr_i = 1; mask_wdata_i = m;
        finish_cycle();
    endtask

    task automatic rx_event();
        @(negedge clk); rx_evt_i = 1; finish_cycle();
    endtask

    task automatic do_ack();
        @(negedge clk); ack_i = 1; finish_cycle();
    endtask

    task automatic clr_eob(input logic [1:0] c);
        @(negedge clk); eob_clr_i = c; finish_cycle();
    endtask

    initial begin
        #(8 * 50000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        check("R9 valid", int'(req_valid_o), 0);
        check("R9 mask", int'(dma_mask_o), 0);
        check("R9 eob", int'(eob_o), 0);
        check("R4 idle level", int'(req_level_o), 7);
        @(negedge clk); rst_n = 1;
        // R7 counter zero after reset: dma ack leaves mask and eob
        set_mask(2'b01);
        rx_event();
        check("R2 rx dma", int'(req_kind_o), 0);
        do_ack();
        check("R7 mask held", int'(dma_mask_o), 1);
        check("R7 no eob", int'(eob_o), 0);
        set_mask(2'b00);

        load_cnt(1'b0, 200);
        load_cnt(1'b1, 200);
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            {rx_evt_i, txb_evt_i, txs_evt_i, mask_wr_i, mask_wdata_i, prio_i, ack_i} = VEC[i][15:6];
            finish_cycle();
            check($sformatf("R1-R5 vec%0d valid", i), int'(req_valid_o), int'(VEC[i][5]));
            check($sformatf("R3 vec%0d kind", i), int'(req_kind_o), int'(VEC[i][4:3]));
            check($sformatf("R4 vec%0d level", i), int'(req_level_o), int'(VEC[i][2:0]));
        end

        // R6 receive countdown to zero
        prio_i = 3'd1;
        load_cnt(1'b0, 2);
        set_mask(2'b01);
        rx_event();
        do_ack();
        check("R6 mask after one", int'(dma_mask_o[0]), 1);
        check("R6 no eob yet", int'(eob_o[0]), 0);
        rx_event();
        check("R6 dma before zero", int'(req_kind_o), 0);
        do_ack();
        check("R6 mask cleared", int'(dma_mask_o[0]), 0);
        check("R6 rx eob", int'(eob_o), 1);
        rx_event();
        check("R2 falls back to irq", int'(req_kind_o), 2);
        do_ack();

        // R8 write-one-to-clear
        clr_eob(2'b10);
        check("R8 other bit no effect", int'(eob_o), 1);
        clr_eob(2'b01);
        check("R8 cleared", int'(eob_o), 0);

        // R6 transmit countdown from shifter event
        load_cnt(1'b1, 1);
        set_mask(2'b10);
        @(negedge clk); txs_evt_i = 1; finish_cycle();
        check("R1 shifter event tx dma", int'(req_kind_o), 1);
        do_ack();
        check("R6 tx eob", int'(eob_o), 2);
        check("R6 tx mask cleared", int'(dma_mask_o), 0);
        repeat (2) @(posedge clk);
        #1;
        check("R8 tx eob held", int'(eob_o), 2);

        // R1 event same cycle as ack keeps pending
        rx_event();
        @(negedge clk); rx_evt_i = 1; ack_i = 1; finish_cycle();
        check("R1 event beats ack", int'(req_valid_o), 1);
        do_ack();
        check("R5 cleared", int'(req_valid_o), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule